// File: doc/BRIEF.md
# Framed SPI Command Responder

This block is an SPI mode-0 slave that trades fixed four-byte frames with a master and is paced by an active-low data-ready output. While data-ready is low the master clocks one request frame into the block and, on the same wires, reads out a response frame that the block prepared beforehand. When the next conversion window opens (the `conv_active` strobe rises), data-ready goes high, the captured request is frozen and checked, and a new response is built from a bank of values. The bank holds the latest ADC sample, a set of 24-bit calibration points, two serial numbers, a revision word, the rate code in force and two 8-bit counts. Once the response and its CRC-8 sit in the transmit register and the conversion window has ended, data-ready falls again.

A request is answered one window later. A request with a wrong CRC, an undefined command, too few or too many bits, or chip select still asserted when the window closes is handled as a plain ADC read. Set-rate commands update an internal rate register and send a one-cycle pulse toward the sampling timer, which lies outside this block along with the converter itself.

Top module: `spi_frame_responder`

## Requirements
- R1: SPI mode 0, MSB first: MOSI is captured on SCLK rising edges and MISO changes after falling edges. The first response bit is on MISO before the first rising edge. MISO reads 0 whenever `cs_n` is high.
- R2: A response is 32 bits: payload bits [31:8], most significant byte first, then a CRC-8 in bits [7:0]. The CRC uses polynomial 0x07, starts at 0x00, has no reflection and no final XOR, and covers the three payload bytes. A request carries a command in bits [15:8] and the same CRC over its bits [31:8] in bits [7:0]. Bits [31:16] of a request are don't-care.
- R3: Command 0x00 returns the `adc_sample` value present while the response is built.
- R4: Commands 0x01 to 0x17 return calibration point k = command − 1, taken from `cal_points[24k+23:24k]`.
- R5: 0x18 returns `sensor_serial`, 0x19 returns `instr_serial`, and 0x1A returns `fw_revision` (major, minor, patch from high byte to low).
- R6: 0x1B returns the rate code in force in the low 3 bits of the payload, with all other bits zero. After reset the rate code is DEFAULT_RATE (0).
- R7: 0x1C to 0x23 return an all-zero payload, set the rate code to command − 0x1C, and raise `rate_set_pulse` for exactly one cycle. `rate_code` changes only in that cycle.
- R8: 0x27 returns `dir_count` and 0x28 returns `load_point_count`, each in the low byte of an otherwise zero payload.
- R9: A request with a CRC mismatch, or with a command of 0x24 to 0x26 or above 0x28, is answered as command 0x00 and never changes the rate code.
- R10: The frame read during one data-ready-low window answers the request captured when the window before it closed. The first window after reset returns ADC data.
- R11: `drdy_n` is high from reset until the first response is loaded, and goes high within two cycles of `conv_active` rising. It falls only after the response is loaded and `conv_active` is low. Clocking a frame out does not raise it.
- R12: A request that has fewer than 32 bits, more than 32 bits, or `cs_n` still low when the window closes is treated as empty and answered with ADC data.
- R13: Arbitrary idle time between bytes of a frame, within one window, has no effect on the exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_active | input | 1 | High while a conversion window is in progress |
| adc_sample | input | 24 | Latest converter result |
| cal_points | input | N_CAL*24 | Calibration points, point k in bits [24k+23:24k] |
| sensor_serial | input | 24 | Sensor serial number |
| instr_serial | input | 24 | Instrument serial number |
| fw_revision | input | 24 | Major, minor, patch bytes |
| dir_count | input | 8 | Number of directions |
| load_point_count | input | 8 | Number of loading points |
| sclk | input | 1 | SPI clock from master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| drdy_n | output | 1 | Active-low data-ready |
| rate_code | output | 3 | Rate code in force |
| rate_set_pulse | output | 1 | One-cycle strobe when the rate code is set |

## Verification
A corrupted frame counter or a shift register that holds stale data shows up as a bad CRC byte or a shifted payload in the very next frame the master reads, one window after the faulty request. A sequencer stuck in the wrong state appears as `drdy_n` that never falls after the conversion window ends, which the bench sees within tens of cycles. A rate register that drifts, or that is written by a request it should reject, appears as a wrong payload for the 0x1B read that follows and as a missing or extra strobe on `rate_set_pulse` in the same window. The sweep covers every command code from 0x00 to 0x2A, so an error in the decode table shows on the exact code that maps wrongly.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned FRAME_W = 32;
   localparam int unsigned PAY_W   = 24;
   localparam int unsigned RATE_W  = 3;
   localparam int unsigned CNT_W   = 8;

   localparam logic [7:0] CRC_POLY = 8'h07;

   localparam logic [7:0] CMD_ADC       = 8'h00;
   localparam logic [7:0] CMD_CAL_FIRST = 8'h01;
   localparam logic [7:0] CMD_SSN       = 8'h18;
   localparam logic [7:0] CMD_ISN       = 8'h19;
   localparam logic [7:0] CMD_REV       = 8'h1A;
   localparam logic [7:0] CMD_RATE_GET  = 8'h1B;
   localparam logic [7:0] CMD_SET_FIRST = 8'h1C;
   localparam logic [7:0] CMD_SET_LAST  = 8'h23;
   localparam logic [7:0] CMD_DIR_CNT   = 8'h27;
   localparam logic [7:0] CMD_LOAD_CNT  = 8'h28;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECODE,
      ST_CRC,
      ST_HOLD,
      ST_OPEN
   } seq_state_t;

   // one message bit into a non-reflected CRC-8
   function automatic logic [7:0] crc8_bit(input logic [7:0] c, input logic b);
      return {c[6:0], 1'b0} ^ ((c[7] ^ b) ? CRC_POLY : 8'h00);
   endfunction

   function automatic logic [7:0] crc8_pay(input logic [PAY_W-1:0] d);
      logic [7:0] c;
      c = 8'h00;
      for (int i = PAY_W - 1; i >= 0; i--) c = crc8_bit(c, d[i]);
      return c;
   endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_in_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_phy.sv
module spi_frame_phy
   import spi_resp_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               cs_n_s,
   input  logic               mosi_s,
   input  logic               cs_n_raw,
   input  logic               enable,
   input  logic               clear,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   output logic               miso,
   output logic [FRAME_W-1:0] rx_word,
   output logic               frame_full
);
   localparam int unsigned CW = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(FRAME_W);

   logic               sclk_d;
   logic               edge_ok;
   logic               rise;
   logic               fall;
   logic [CW-1:0]      bit_cnt;
   logic               overrun;
   logic [FRAME_W-1:0] tx_sr;

   assign edge_ok = enable && !cs_n_s;
   assign rise    = edge_ok && sclk_s && !sclk_d;
   assign fall    = edge_ok && !sclk_s && sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   // receive side: count bits, flag anything past a full frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         overrun <= 1'b0;
         rx_word <= '0;
      end else if (clear) begin
         bit_cnt <= '0;
         overrun <= 1'b0;
      end else if (rise) begin
         if (bit_cnt == FULL_CNT) begin
            overrun <= 1'b1;
         end else begin
            rx_word <= {rx_word[FRAME_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   // transmit side: next bit presented after each falling edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tx_sr <= '0;
      else if (load) tx_sr <= load_word;
      else if (fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
   end

   assign miso       = cs_n_raw ? 1'b0 : tx_sr[FRAME_W-1];
   assign frame_full = (bit_cnt == FULL_CNT) && !overrun;

   a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FULL_CNT);

   a_r1_rx_frozen_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(rx_word));
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
   import spi_resp_pkg::*;
#(
   parameter bit SERIAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PAY_W-1:0] data,
   output logic [7:0]       crc,
   output logic             done
);
   generate
      if (SERIAL) begin : g_serial
         localparam int unsigned NW = $clog2(PAY_W + 1);
         logic [NW-1:0]    left;
         logic [PAY_W-1:0] sh;
         logic             busy;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               crc  <= '0;
               sh   <= '0;
               left <= '0;
               busy <= 1'b0;
               done <= 1'b0;
            end else begin
               done <= 1'b0;
               if (start) begin
                  crc  <= '0;
                  sh   <= data;
                  left <= NW'(PAY_W);
                  busy <= 1'b1;
               end else if (busy) begin
                  crc  <= crc8_bit(crc, sh[PAY_W-1]);
                  sh   <= {sh[PAY_W-2:0], 1'b0};
                  left <= left - 1'b1;
                  if (left == NW'(1)) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end
               end
            end
         end
      end else begin : g_parallel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               crc  <= '0;
               done <= 1'b0;
            end else begin
               done <= start;
               if (start) crc <= crc8_pay(data);
            end
         end
      end
   endgenerate

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/spi_resp_bank.sv
module spi_resp_bank
   import spi_resp_pkg::*;
#(
   parameter int unsigned N_CAL = 23
) (
   input  logic [7:0]             cmd,
   input  logic                   req_ok,
   input  logic [PAY_W-1:0]       adc_sample,
   input  logic [N_CAL*PAY_W-1:0] cal_points,
   input  logic [PAY_W-1:0]       sensor_serial,
   input  logic [PAY_W-1:0]       instr_serial,
   input  logic [PAY_W-1:0]       fw_revision,
   input  logic [CNT_W-1:0]       dir_count,
   input  logic [CNT_W-1:0]       load_point_count,
   input  logic [RATE_W-1:0]      rate_cur,
   output logic [PAY_W-1:0]       payload,
   output logic                   set_en,
   output logic [RATE_W-1:0]      set_code
);
   localparam int unsigned CAL_IW = (N_CAL > 1) ? $clog2(N_CAL) : 1;

   logic [PAY_W-1:0]  cal_arr [N_CAL];
   logic [7:0]        cal_off;
   logic [CAL_IW-1:0] cal_idx;
   logic              cal_hit;
   logic [7:0]        set_off;

   for (genvar g = 0; g < N_CAL; g++) begin : g_cal
      assign cal_arr[g] = cal_points[g*PAY_W +: PAY_W];
   end

   assign cal_off = cmd - CMD_CAL_FIRST;
   assign cal_idx = cal_off[CAL_IW-1:0];
   assign cal_hit = req_ok && (cmd >= CMD_CAL_FIRST) && (cal_off < 8'(N_CAL));
   assign set_off = cmd - CMD_SET_FIRST;

   always_comb begin
      payload  = adc_sample;
      set_en   = 1'b0;
      set_code = '0;
      if (cal_hit) begin
         payload = cal_arr[cal_idx];
      end else if (req_ok) begin
         case (cmd)
            CMD_SSN:      payload = sensor_serial;
            CMD_ISN:      payload = instr_serial;
            CMD_REV:      payload = fw_revision;
            CMD_RATE_GET: payload = {{(PAY_W-RATE_W){1'b0}}, rate_cur};
            CMD_DIR_CNT:  payload = {{(PAY_W-CNT_W){1'b0}}, dir_count};
            CMD_LOAD_CNT: payload = {{(PAY_W-CNT_W){1'b0}}, load_point_count};
            default: begin
               if (cmd >= CMD_SET_FIRST && cmd <= CMD_SET_LAST) begin
                  payload  = '0;
                  set_en   = 1'b1;
                  set_code = set_off[RATE_W-1:0];
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/spi_frame_responder.sv
module spi_frame_responder
   import spi_resp_pkg::*;
#(
   parameter int unsigned     N_CAL        = 23,
   parameter int unsigned     SYNC_STAGES  = 2,
   parameter bit              CRC_SERIAL   = 1'b0,
   parameter logic [2:0]      DEFAULT_RATE = 3'd0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   conv_active,
   input  logic [23:0]            adc_sample,
   input  logic [N_CAL*24-1:0]    cal_points,
   input  logic [23:0]            sensor_serial,
   input  logic [23:0]            instr_serial,
   input  logic [23:0]            fw_revision,
   input  logic [7:0]             dir_count,
   input  logic [7:0]             load_point_count,
   input  logic                   sclk,
   input  logic                   cs_n,
   input  logic                   mosi,
   output logic                   miso,
   output logic                   drdy_n,
   output logic [2:0]             rate_code,
   output logic                   rate_set_pulse
);
   generate
      if (N_CAL < 1 || N_CAL > 23) begin : g_bad_ncal
         $error("N_CAL must lie in 1..23");
      end
      if (PAY_W != 24 || RATE_W != 3 || CNT_W != 8) begin : g_bad_widths
         $error("frame field widths do not match the port list");
      end
   endgenerate

   seq_state_t         st;
   logic               conv_d;
   logic               conv_rise;
   logic               snap;
   logic [2:0]         sync_q;
   logic               sclk_s;
   logic               cs_n_s;
   logic               mosi_s;
   logic [FRAME_W-1:0] rx_word;
   logic               frame_full;
   logic [FRAME_W-1:0] req_q;
   logic               req_full;
   logic               req_ok;
   logic [PAY_W-1:0]   bank_pay;
   logic               set_en;
   logic [RATE_W-1:0]  set_code;
   logic [PAY_W-1:0]   payload_q;
   logic [RATE_W-1:0]  rate_q;
   logic               crc_start;
   logic [7:0]         crc_val;
   logic               crc_done;
   logic               tx_load;

   spi_in_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, cs_n, mosi}),
      .q     (sync_q)
   );
   assign {sclk_s, cs_n_s, mosi_s} = sync_q;

   assign conv_rise = conv_active && !conv_d;
   assign snap      = conv_rise && (st == ST_IDLE || st == ST_OPEN);

   spi_frame_phy u_phy (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (sclk_s),
      .cs_n_s     (cs_n_s),
      .mosi_s     (mosi_s),
      .cs_n_raw   (cs_n),
      .enable     (st == ST_OPEN),
      .clear      (snap),
      .load       (tx_load),
      .load_word  ({payload_q, crc_val}),
      .miso       (miso),
      .rx_word    (rx_word),
      .frame_full (frame_full)
   );

   assign req_ok = req_full && (crc8_pay(req_q[FRAME_W-1:BYTE_W]) == req_q[BYTE_W-1:0]);

   spi_resp_bank #(.N_CAL(N_CAL)) u_bank (
      .cmd              (req_q[2*BYTE_W-1:BYTE_W]),
      .req_ok           (req_ok),
      .adc_sample       (adc_sample),
      .cal_points       (cal_points),
      .sensor_serial    (sensor_serial),
      .instr_serial     (instr_serial),
      .fw_revision      (fw_revision),
      .dir_count        (dir_count),
      .load_point_count (load_point_count),
      .rate_cur         (rate_q),
      .payload          (bank_pay),
      .set_en           (set_en),
      .set_code         (set_code)
   );

   spi_crc_unit #(.SERIAL(CRC_SERIAL)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (crc_start),
      .data  (payload_q),
      .crc   (crc_val),
      .done  (crc_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st             <= ST_IDLE;
         conv_d         <= 1'b0;
         drdy_n         <= 1'b1;
         req_q          <= '0;
         req_full       <= 1'b0;
         payload_q      <= '0;
         rate_q         <= DEFAULT_RATE;
         rate_set_pulse <= 1'b0;
         crc_start      <= 1'b0;
         tx_load        <= 1'b0;
      end else begin
         conv_d         <= conv_active;
         rate_set_pulse <= 1'b0;
         crc_start      <= 1'b0;
         tx_load        <= 1'b0;
         case (st)
            ST_IDLE, ST_OPEN: begin
               if (conv_rise) begin
                  drdy_n   <= 1'b1;
                  req_q    <= rx_word;
                  req_full <= frame_full && cs_n_s && (st == ST_OPEN);
                  st       <= ST_DECODE;
               end
            end
            ST_DECODE: begin
               payload_q <= bank_pay;
               if (set_en) begin
                  rate_q         <= set_code;
                  rate_set_pulse <= 1'b1;
               end
               crc_start <= 1'b1;
               st        <= ST_CRC;
            end
            ST_CRC: begin
               if (crc_done) begin
                  tx_load <= 1'b1;
                  st      <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (!conv_active && !tx_load) begin
                  drdy_n <= 1'b0;
                  st     <= ST_OPEN;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rate_code = rate_q;

   a_r11_drdy_high_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
      conv_d |-> drdy_n);

   a_r10_drdy_falls_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_n) |-> $past(st == ST_HOLD));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rate_set_pulse |=> !rate_set_pulse);

   a_r7_rate_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate_q) |-> rate_set_pulse);
endmodule

// File: tb/spi_frame_responder_tb.sv
module spi_frame_responder_tb;
   localparam int N_CAL = 23;
   localparam int HALF  = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               conv_active = 1'b0;
   logic [23:0]        adc_sample = '0;
   logic [N_CAL*24-1:0] cal_points;
   logic [23:0]        sensor_serial = 24'h5A1234;
   logic [23:0]        instr_serial  = 24'hC3B2A1;
   logic [23:0]        fw_revision   = 24'h060100;
   logic [7:0]         dir_count     = 8'h02;
   logic [7:0]         load_point_count = 8'h0B;
   logic               sclk = 1'b0;
   logic               cs_n = 1'b1;
   logic               mosi = 1'b0;
   logic               miso;
   logic               drdy_n;
   logic [2:0]         rate_code;
   logic               rate_set_pulse;

   int checks = 0;
   int failures = 0;
   int pulse_rises = 0;
   int pulse_highs = 0;
   logic pulse_d = 1'b0;
   logic finished = 1'b0;

   logic [31:0] exp_pending;
   string       exp_tag;
   logic [2:0]  model_rate;

   always #2 clk = ~clk;

   spi_frame_responder u_dut (
      .clk (clk), .rst_n (rst_n), .conv_active (conv_active),
      .adc_sample (adc_sample), .cal_points (cal_points),
      .sensor_serial (sensor_serial), .instr_serial (instr_serial),
      .fw_revision (fw_revision), .dir_count (dir_count),
      .load_point_count (load_point_count), .sclk (sclk), .cs_n (cs_n),
      .mosi (mosi), .miso (miso), .drdy_n (drdy_n), .rate_code (rate_code),
      .rate_set_pulse (rate_set_pulse)
   );

   always @(posedge clk) begin
      pulse_d <= rate_set_pulse;
      if (rate_set_pulse) pulse_highs++;
      if (rate_set_pulse && !pulse_d) pulse_rises++;
   end

   function automatic logic [7:0] ref_crc(input logic [23:0] d);
      logic [7:0] c = 8'h00;
      for (int b = 2; b >= 0; b--) begin
         c = c ^ d[b*8 +: 8];
         for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [23:0] cal_val(input int k);
      return 24'h0A0000 + 24'(k) * 24'h010203;
   endfunction

   function automatic logic [31:0] mk_req(input logic [7:0] cmd, input logic [7:0] salt);
      logic [23:0] p = {salt, 8'h3C ^ salt, cmd};
      return {p, ref_crc(p)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one master transfer; compares what was read against the pending response
   task automatic frame(input logic [31:0] req, input int nbits, input int gap,
                        input bit hold_cs);
      logic [31:0] got = '0;
      @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 32) ? req[31-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < 32) got = {got[30:0], miso};
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
         if ((i % 8) == 7) repeat (gap) @(negedge clk);
      end
      repeat (HALF) @(negedge clk);
      if (nbits >= 32) check(exp_tag, got, exp_pending);
      else check({exp_tag, " R12 prefix"}, got, exp_pending >> (32 - nbits));
      check("R11 drdy stays low after read", {31'd0, drdy_n}, 32'd0);
      if (!hold_cs) begin
         cs_n = 1'b1;
         @(negedge clk);
         check("R1 miso idle with cs high", {31'd0, miso}, 32'd0);
      end
      repeat (4) @(negedge clk);
   endtask

   function automatic string tag_of(input logic [7:0] cmd, input bit ok);
      if (!ok) return "R2 R10 R9 R12 fallback";
      if (cmd == 8'h00) return "R2 R10 R3 adc";
      if (cmd <= 8'h17) return "R2 R10 R4 cal";
      if (cmd <= 8'h1A) return "R2 R10 R5 ident";
      if (cmd == 8'h1B) return "R2 R10 R6 rate";
      if (cmd <= 8'h23) return "R2 R10 R7 set";
      if (cmd == 8'h27 || cmd == 8'h28) return "R2 R10 R8 count";
      return "R2 R10 R9 undefined";
   endfunction

   // conversion window: captures request, builds the next expected response
   task automatic window(input logic [23:0] adc, input logic [31:0] req, input bit full);
      int p0 = pulse_rises;
      int h0 = pulse_highs;
      logic [7:0]  cmd = req[15:8];
      bit          ok = full && (ref_crc(req[31:8]) == req[7:0]);
      bit          is_set = 1'b0;
      logic [23:0] pay;
      int          wait_n = 0;
      adc_sample  = adc;
      conv_active = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 drdy high in window", {31'd0, drdy_n}, 32'd1);
      cs_n = 1'b1;
      if (!ok) pay = adc;
      else if (cmd == 8'h00) pay = adc;
      else if (cmd <= 8'h17) pay = cal_val(int'(cmd) - 1);
      else if (cmd == 8'h18) pay = sensor_serial;
      else if (cmd == 8'h19) pay = instr_serial;
      else if (cmd == 8'h1A) pay = fw_revision;
      else if (cmd == 8'h1B) pay = {21'd0, model_rate};
      else if (cmd <= 8'h23) begin
         pay = 24'd0;
         is_set = 1'b1;
         model_rate = 3'(cmd - 8'h1C);
      end
      else if (cmd == 8'h27) pay = {16'd0, dir_count};
      else if (cmd == 8'h28) pay = {16'd0, load_point_count};
      else pay = adc;
      repeat (40) @(negedge clk);
      check("R11 drdy high until window ends", {31'd0, drdy_n}, 32'd1);
      conv_active = 1'b0;
      while (drdy_n !== 1'b0 && wait_n < 200) begin
         @(negedge clk);
         wait_n++;
      end
      check("R11 drdy falls after window", {31'd0, drdy_n}, 32'd0);
      check("R7 R9 rate strobe count", 32'(pulse_rises - p0), is_set ? 32'd1 : 32'd0);
      check("R7 strobe width", 32'(pulse_highs - h0), is_set ? 32'd1 : 32'd0);
      check("R6 R7 R9 rate code", {29'd0, rate_code}, {29'd0, model_rate});
      exp_pending = {pay, ref_crc(pay)};
      exp_tag     = tag_of(cmd, ok);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < N_CAL; k++) cal_points[k*24 +: 24] = cal_val(k);
      model_rate = 3'd0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset drdy high", {31'd0, drdy_n}, 32'd1);
      check("R1 reset miso low", {31'd0, miso}, 32'd0);
      check("R6 reset rate code", {29'd0, rate_code}, 32'd0);
      check("R7 reset strobe low", {31'd0, rate_set_pulse}, 32'd0);
      repeat (20) @(negedge clk);
      check("R11 drdy high before first load", {31'd0, drdy_n}, 32'd1);

      window(24'h123456, 32'd0, 1'b0);
      exp_tag = "R2 R10 R3 first window adc";

      for (int c = 0; c <= 8'h2A; c++) begin
         logic [31:0] rq = mk_req(8'(c), 8'(c * 7 + 1));
         frame(rq, 32, 0, 1'b0);
         window(24'h800000 ^ 24'(c * 24'h01F3A7), rq, 1'b1);
      end

      // bad CRC on an identity read and on a set-rate request
      begin
         logic [31:0] rq = mk_req(8'h19, 8'h44) ^ 32'h1;
         frame(rq, 32, 0, 1'b0);
         window(24'hABCDEF, rq, 1'b1);
         rq = mk_req(8'h20, 8'h45) ^ 32'h80;
         frame(rq, 32, 0, 1'b0);
         window(24'h0F0F0F, rq, 1'b1);
      end
      // rate set followed by readback
      frame(mk_req(8'h1E, 8'h10), 32, 0, 1'b0);
      window(24'h000001, mk_req(8'h1E, 8'h10), 1'b1);
      frame(mk_req(8'h1B, 8'h11), 32, 0, 1'b0);
      window(24'h000002, mk_req(8'h1B, 8'h11), 1'b1);
      // short frame
      frame(mk_req(8'h18, 8'h20), 16, 0, 1'b0);
      window(24'h333333, mk_req(8'h18, 8'h20), 1'b0);
      // chip select still low when the window closes
      frame(mk_req(8'h1A, 8'h21), 32, 0, 1'b1);
      window(24'h444444, mk_req(8'h1A, 8'h21), 1'b0);
      // overlong frame
      frame(mk_req(8'h27, 8'h22), 33, 0, 1'b0);
      window(24'h555555, mk_req(8'h27, 8'h22), 1'b0);
      // R13: idle gaps between bytes
      frame(mk_req(8'h18, 8'h23), 32, 37, 1'b0);
      window(24'h666666, mk_req(8'h18, 8'h23), 1'b1);
      exp_tag = {exp_tag, " R13 after gaps"};
      frame(mk_req(8'h00, 8'h24), 32, 11, 1'b0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule